// File: doc/BRIEF.md
# USB Endpoint Transmit Handshake Controller

This block keeps the transmit-side control state of a small USB device function with up to 16 endpoints. It holds a device address register with an enable bit. For each endpoint it holds a completion flag, a data toggle bit, a transmit status code and an endpoint kind (bulk, control, interrupt or isochronous). Decoded token events come in from the serial engine. The block answers each one, one cycle later, with a response decision and, for a data response, the data PID to send.

The completion flag also throttles the endpoint. Once a transfer has completed, the endpoint answers NAK until software clears the flag. SETUP tokens are the exception and get no answer at all while the flag is set. The toggle bit follows rules that depend on the endpoint kind. On isochronous endpoints it acts as a buffer selector that flips at the end of every sent packet, and those endpoints always send DATA0. A USB reset input (from the bus or forced by software) clears the address register and each endpoint's configuration, but leaves the completion flags as they were.

Top module: `usb_eptx_ctrl`

## Requirements
- R1: A token is accepted only when address register bit 7 (enable) is 1, the token address equals register bits 6:0, and the endpoint number is below NUM_EP. An unaccepted token gets response code 0 (none).
- R2: A USB reset clears the address register to 00h. It also clears the kind, status and toggle fields of every endpoint, but leaves each completion flag unchanged.
- R3: The completion flag is set on a received ACK for a non-isochronous endpoint, or on the end of a sent packet for an isochronous endpoint. A software write with bit 7 = 0 clears the flag. A write with bit 7 = 1 leaves it unchanged.
- R4: If a hardware set and a software clear of the completion flag fall in the same cycle, the flag ends up set. If a software toggle write and a hardware toggle inversion fall in the same cycle, the written toggle value is kept.
- R5: On a non-isochronous endpoint with status valid and the completion flag set, IN and OUT tokens get NAK (code 3) and SETUP tokens get no response (code 0).
- R6: An isochronous endpoint with status valid answers IN with data (code 1) and DATA0 (data1_o = 0), whatever its completion flag. OUT and SETUP tokens get no response.
- R7: On a non-isochronous endpoint with status valid and the flag clear, IN gets data with data1_o equal to the toggle bit, and OUT gets ACK (code 2). A received ACK inverts the toggle bit.
- R8: Any accepted SETUP token to a control endpoint (kind 01) forces its toggle bit to 1. With status valid and the flag clear, the SETUP itself is answered with ACK.
- R9: On an isochronous endpoint (kind 10), the end of a sent packet inverts the toggle bit and a received ACK changes nothing. On a non-isochronous endpoint, the end of a sent packet changes nothing.
- R10: The status field encodes 00 = disabled, 01 = stall, 10 = NAK, 11 = valid. A disabled endpoint gives no response. A stall endpoint answers STALL (code 4). A NAK endpoint answers NAK. An isochronous endpoint in stall or NAK status gives no response.
- R11: The software map is: register addresses 0 to NUM_EP-1 are the endpoints, address 16 is the device address register, and all other addresses read 0. An endpoint register holds the flag in bit 7, the kind in bits 4:3, the status in bits 2:1 and the toggle in bit 0, and bits 6:5 read 0. A software write sets kind, status and toggle directly.
- R12: dec_vld_o pulses in the cycle after each tok_valid_i. rsp_o and data1_o hold the decision for that token in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| usb_rst_i | input | 1 | USB reset, from the bus or forced |
| tok_valid_i | input | 1 | Token event strobe |
| tok_pid_i | input | 2 | Token type: 0 IN, 1 OUT, 2 SETUP |
| tok_addr_i | input | 7 | Token device address |
| tok_ep_i | input | 4 | Token endpoint number |
| hs_ack_i | input | 1 | ACK handshake received after a sent packet |
| tx_end_i | input | 1 | End of a sent data packet |
| ev_ep_i | input | 4 | Endpoint of the handshake or end event |
| sw_we_i | input | 1 | Software write strobe |
| sw_addr_i | input | 5 | Software register address |
| sw_wdata_i | input | 8 | Software write data |
| sw_rdata_o | output | 8 | Software read data, combinational |
| dec_vld_o | output | 1 | Decision strobe |
| rsp_o | output | 3 | Response: 0 none, 1 data, 2 ACK, 3 NAK, 4 STALL |
| data1_o | output | 1 | Data PID for a data response: 0 DATA0, 1 DATA1 |

## Verification
A wrong toggle bit shows up on data1_o at the next IN token's decision, one cycle after the token. It also appears in bit 0 of the endpoint's register as soon as the event that corrupted it has been clocked. A stuck or lost completion flag turns a data or ACK answer into NAK, or the reverse, on the very next token. A wrong address register shows up as a lost or stray response. For these reasons the bench reads back every endpoint touched by an event, and then sends a token to check that the stored state drives the decision as expected.

// File: rtl/usb_eptx_pkg.sv
package usb_eptx_pkg;
  typedef enum logic [1:0] {PID_IN = 2'd0, PID_OUT = 2'd1, PID_SETUP = 2'd2} tok_pid_e;
  typedef enum logic [1:0] {ST_OFF = 2'd0, ST_STALL = 2'd1, ST_NAK = 2'd2, ST_VALID = 2'd3} tx_stat_e;
  typedef enum logic [1:0] {KD_BULK = 2'd0, KD_CTRL = 2'd1, KD_ISO = 2'd2, KD_INTR = 2'd3} ep_kind_e;
  typedef enum logic [2:0] {
    RSP_NONE = 3'd0, RSP_DATA = 3'd1, RSP_ACK = 3'd2, RSP_NAK = 3'd3, RSP_STALL = 3'd4
  } rsp_e;

  typedef struct packed {
    logic     done;
    ep_kind_e kind;
    tx_stat_e stat;
    logic     tog;
  } ep_state_t;

  localparam logic [4:0] ADDR_REG_SEL = 5'd16;

  function automatic logic [7:0] ep_to_reg(ep_state_t s);
    return {s.done, 2'b00, s.kind, s.stat, s.tog};
  endfunction
endpackage

// File: rtl/usb_eptx_addr.sv
module usb_eptx_addr (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       usb_rst_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic [6:0] tok_addr_i,
  output logic [7:0] addr_q_o,
  output logic       match_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_q_o <= '0;
    else if (usb_rst_i) addr_q_o <= '0;
    else if (we_i)      addr_q_o <= wdata_i;
  end

  assign match_o = addr_q_o[7] && (tok_addr_i == addr_q_o[6:0]);
endmodule

// File: rtl/usb_eptx_ep.sv
module usb_eptx_ep
  import usb_eptx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      usb_rst_i,
  input  logic      we_i,
  input  logic      wdone_i,
  input  logic [4:0] wcfg_i,
  input  logic      setup_hit_i,
  input  logic      ack_hit_i,
  input  logic      end_hit_i,
  output ep_state_t st_o
);
  logic is_iso, is_ctrl, complete;

  assign is_iso   = (st_o.kind == KD_ISO);
  assign is_ctrl  = (st_o.kind == KD_CTRL);
  assign complete = is_iso ? end_hit_i : ack_hit_i;

  // completion flag: hardware set beats software clear, untouched by USB reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 st_o.done <= 1'b0;
    else if (complete)           st_o.done <= 1'b1;
    else if (we_i && !wdone_i)   st_o.done <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_o.kind <= KD_BULK;
      st_o.stat <= ST_OFF;
      st_o.tog  <= 1'b0;
    end else if (usb_rst_i) begin
      st_o.kind <= KD_BULK;
      st_o.stat <= ST_OFF;
      st_o.tog  <= 1'b0;
    end else if (we_i) begin
      st_o.kind <= ep_kind_e'(wcfg_i[4:3]);
      st_o.stat <= tx_stat_e'(wcfg_i[2:1]);
      st_o.tog  <= wcfg_i[0];
    end else if (setup_hit_i && is_ctrl) begin
      st_o.tog  <= 1'b1;
    end else if (complete) begin
      st_o.tog  <= ~st_o.tog;
    end
  end
endmodule

// File: rtl/usb_eptx_resp.sv
module usb_eptx_resp
  import usb_eptx_pkg::*;
(
  input  logic      acc_i,
  input  logic [1:0] pid_i,
  input  ep_state_t st_i,
  output rsp_e      rsp_o,
  output logic      data1_o
);
  logic is_iso, is_in, is_out, is_setup;

  assign is_iso   = (st_i.kind == KD_ISO);
  assign is_in    = (pid_i == PID_IN);
  assign is_out   = (pid_i == PID_OUT);
  assign is_setup = (pid_i == PID_SETUP);

  always_comb begin
    rsp_o   = RSP_NONE;
    data1_o = 1'b0;
    if (acc_i && (is_in || is_out || is_setup)) begin
      unique case (st_i.stat)
        ST_OFF:   rsp_o = RSP_NONE;
        ST_STALL: rsp_o = is_iso ? RSP_NONE : RSP_STALL;
        ST_NAK:   rsp_o = is_iso ? RSP_NONE : RSP_NAK;
        ST_VALID: begin
          if (is_iso) begin
            // no handshake phase: flow control does not apply, DATA0 only
            if (is_in) rsp_o = RSP_DATA;
          end else if (st_i.done) begin
            rsp_o = is_setup ? RSP_NONE : RSP_NAK;
          end else if (is_in) begin
            rsp_o   = RSP_DATA;
            data1_o = st_i.tog;
          end else if (is_out) begin
            rsp_o = RSP_ACK;
          end else if (st_i.kind == KD_CTRL) begin
            rsp_o = RSP_ACK;
          end
        end
        default:  rsp_o = RSP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/usb_eptx_ctrl.sv
module usb_eptx_ctrl
  import usb_eptx_pkg::*;
#(
  parameter int NUM_EP = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       usb_rst_i,
  input  logic       tok_valid_i,
  input  logic [1:0] tok_pid_i,
  input  logic [6:0] tok_addr_i,
  input  logic [3:0] tok_ep_i,
  input  logic       hs_ack_i,
  input  logic       tx_end_i,
  input  logic [3:0] ev_ep_i,
  input  logic       sw_we_i,
  input  logic [4:0] sw_addr_i,
  input  logic [7:0] sw_wdata_i,
  output logic [7:0] sw_rdata_o,
  output logic       dec_vld_o,
  output logic [2:0] rsp_o,
  output logic       data1_o
);
  logic [7:0]        dev_addr;
  logic              tok_match, tok_acc;
  logic [NUM_EP-1:0] tok_sel, sw_sel, done_vec, iso_vec, valid_vec;
  ep_state_t         ep_st [NUM_EP];
  ep_state_t         sel_st;
  rsp_e              rsp_d;
  logic              data1_d;

  usb_eptx_addr u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .usb_rst_i  (usb_rst_i),
    .we_i       (sw_we_i && (sw_addr_i == ADDR_REG_SEL)),
    .wdata_i    (sw_wdata_i),
    .tok_addr_i (tok_addr_i),
    .addr_q_o   (dev_addr),
    .match_o    (tok_match)
  );

  assign tok_acc = tok_valid_i && tok_match && (|tok_sel);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    assign tok_sel[i]   = (tok_ep_i == 4'(i));
    assign sw_sel[i]    = (sw_addr_i == 5'(i));
    assign done_vec[i]  = ep_st[i].done;
    assign iso_vec[i]   = (ep_st[i].kind == KD_ISO);
    assign valid_vec[i] = (ep_st[i].stat == ST_VALID);

    usb_eptx_ep u_ep (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .usb_rst_i   (usb_rst_i),
      .we_i        (sw_we_i && sw_sel[i]),
      .wdone_i     (sw_wdata_i[7]),
      .wcfg_i      (sw_wdata_i[4:0]),
      .setup_hit_i (tok_acc && tok_sel[i] && (tok_pid_i == PID_SETUP)),
      .ack_hit_i   (hs_ack_i && (ev_ep_i == 4'(i))),
      .end_hit_i   (tx_end_i && (ev_ep_i == 4'(i))),
      .st_o        (ep_st[i])
    );
  end

  always_comb begin
    sel_st     = '0;
    sw_rdata_o = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (tok_sel[i]) sel_st = ep_st[i];
      if (sw_sel[i])  sw_rdata_o = ep_to_reg(ep_st[i]);
    end
    if (sw_addr_i == ADDR_REG_SEL) sw_rdata_o = dev_addr;
  end

  usb_eptx_resp u_resp (
    .acc_i   (tok_acc),
    .pid_i   (tok_pid_i),
    .st_i    (sel_st),
    .rsp_o   (rsp_d),
    .data1_o (data1_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_vld_o <= 1'b0;
      rsp_o     <= RSP_NONE;
      data1_o   <= 1'b0;
    end else begin
      dec_vld_o <= tok_valid_i;
      rsp_o     <= rsp_d;
      data1_o   <= data1_d;
    end
  end
endmodule

// File: rtl/usb_eptx_ctrl_chk.sv
module usb_eptx_ctrl_chk #(
  parameter int NUM_EP = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              usb_rst_i,
  input logic              tok_valid_i,
  input logic [6:0]        tok_addr_i,
  input logic [3:0]        tok_ep_i,
  input logic              hs_ack_i,
  input logic              tx_end_i,
  input logic [3:0]        ev_ep_i,
  input logic              sw_we_i,
  input logic [4:0]        sw_addr_i,
  input logic              wdone_i,
  input logic              dec_vld_o,
  input logic [2:0]        rsp_o,
  input logic              data1_o,
  input logic [7:0]        dev_addr,
  input logic [NUM_EP-1:0] done_vec,
  input logic [NUM_EP-1:0] iso_vec,
  input logic [NUM_EP-1:0] valid_vec
);
  logic acc, in_rng;
  assign in_rng = int'(tok_ep_i) < NUM_EP;
  assign acc    = dev_addr[7] && (tok_addr_i == dev_addr[6:0]) && in_rng;

  a_r12_vld_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_valid_i |=> dec_vld_o);
  a_r12_no_stray_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tok_valid_i |=> !dec_vld_o);
  a_r1_reject_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_i && !acc) |=> (rsp_o == 3'd0));
  a_r2_addr_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usb_rst_i |=> (dev_addr == 8'h00));
  a_r5_flow_nak: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_i && acc && valid_vec[tok_ep_i] && !iso_vec[tok_ep_i] && done_vec[tok_ep_i])
    |=> (rsp_o == 3'd3 || rsp_o == 3'd0));
  a_r6_iso_data0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_i && in_rng && iso_vec[tok_ep_i]) |=> !data1_o);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_flag
    a_r3_set_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_vec[i]) |-> ($past(hs_ack_i || tx_end_i) && ($past(ev_ep_i) == 4'(i))));
    a_r3_clear_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(done_vec[i]) |-> $past(sw_we_i && (sw_addr_i == 5'(i)) && !wdone_i));
    a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((hs_ack_i && !iso_vec[i] || tx_end_i && iso_vec[i]) && (ev_ep_i == 4'(i)))
      |=> done_vec[i]);
  end
endmodule

bind usb_eptx_ctrl usb_eptx_ctrl_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .usb_rst_i   (usb_rst_i),
  .tok_valid_i (tok_valid_i),
  .tok_addr_i  (tok_addr_i),
  .tok_ep_i    (tok_ep_i),
  .hs_ack_i    (hs_ack_i),
  .tx_end_i    (tx_end_i),
  .ev_ep_i     (ev_ep_i),
  .sw_we_i     (sw_we_i),
  .sw_addr_i   (sw_addr_i),
  .wdone_i     (sw_wdata_i[7]),
  .dec_vld_o   (dec_vld_o),
  .rsp_o       (rsp_o),
  .data1_o     (data1_o),
  .dev_addr    (dev_addr),
  .done_vec    (done_vec),
  .iso_vec     (iso_vec),
  .valid_vec   (valid_vec)
);

// File: tb/usb_eptx_ctrl_test.sv
`timescale 1ns/1ps
module usb_eptx_ctrl_test;
  localparam int P_IN = 0, P_OUT = 1, P_SETUP = 2;
  localparam int NONE = 0, DATA = 1, ACK = 2, NAK = 3, STALL = 4;

  logic       clk = 1'b0, rst_ni = 1'b0, usb_rst_i = 1'b0;
  logic       tok_valid_i = 1'b0;
  logic [1:0] tok_pid_i = '0;
  logic [6:0] tok_addr_i = '0;
  logic [3:0] tok_ep_i = '0;
  logic       hs_ack_i = 1'b0, tx_end_i = 1'b0;
  logic [3:0] ev_ep_i = '0;
  logic       sw_we_i = 1'b0;
  logic [4:0] sw_addr_i = '0;
  logic [7:0] sw_wdata_i = '0;
  logic [7:0] sw_rdata_o;
  logic       dec_vld_o, data1_o;
  logic [2:0] rsp_o;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  usb_eptx_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .usb_rst_i(usb_rst_i),
    .tok_valid_i(tok_valid_i), .tok_pid_i(tok_pid_i), .tok_addr_i(tok_addr_i),
    .tok_ep_i(tok_ep_i), .hs_ack_i(hs_ack_i), .tx_end_i(tx_end_i), .ev_ep_i(ev_ep_i),
    .sw_we_i(sw_we_i), .sw_addr_i(sw_addr_i), .sw_wdata_i(sw_wdata_i),
    .sw_rdata_o(sw_rdata_o), .dec_vld_o(dec_vld_o), .rsp_o(rsp_o), .data1_o(data1_o)
  );

  task automatic check(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sw_wr(int a, int d);
    @(negedge clk);
    sw_we_i = 1'b1; sw_addr_i = 5'(a); sw_wdata_i = 8'(d);
    @(negedge clk);
    sw_we_i = 1'b0;
  endtask

  task automatic rd_chk(string tag, int a, int exp);
    @(negedge clk);
    sw_addr_i = 5'(a);
    #1 check(tag, int'(sw_rdata_o), exp);
  endtask

  task automatic tok_chk(string tag, int pid, int addr, int ep, int exp_rsp, int exp_d1);
    @(negedge clk);
    tok_valid_i = 1'b1; tok_pid_i = 2'(pid); tok_addr_i = 7'(addr); tok_ep_i = 4'(ep);
    @(negedge clk);
    tok_valid_i = 1'b0;
    check({tag, " vld"}, int'(dec_vld_o), 1);
    check({tag, " rsp"}, int'(rsp_o), exp_rsp);
    if (exp_rsp == DATA) check({tag, " pid"}, int'(data1_o), exp_d1);
  endtask

  task automatic ev(bit ack, bit fin, int ep);
    @(negedge clk);
    hs_ack_i = ack; tx_end_i = fin; ev_ep_i = 4'(ep);
    @(negedge clk);
    hs_ack_i = 1'b0; tx_end_i = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R2 addr after reset", 16, 8'h00);
    rd_chk("R11 ep0 after reset", 0, 8'h00);
    rd_chk("R11 unmapped reads 0", 20, 8'h00);
    check("R12 idle vld", int'(dec_vld_o), 0);
  endtask

  task automatic t_match;
    sw_wr(16, 8'h85);
    sw_wr(1, 8'h06);              // bulk, valid, tog 0
    rd_chk("R11 ep1 readback", 1, 8'h06);
    tok_chk("R1 wrong addr", P_IN, 6, 1, NONE, 0);
    sw_wr(16, 8'h05);
    tok_chk("R1 disabled", P_IN, 5, 1, NONE, 0);
    sw_wr(16, 8'h85);
    tok_chk("R7 IN DATA0", P_IN, 5, 1, DATA, 0);
    tok_chk("R7 OUT ack", P_OUT, 5, 1, ACK, 0);
    @(negedge clk);
    check("R12 pulse ends", int'(dec_vld_o), 0);
  endtask

  task automatic t_flow;
    ev(1, 0, 1);
    rd_chk("R3 R7 ack sets flag, inverts tog", 1, 8'h87);
    tok_chk("R5 IN nak", P_IN, 5, 1, NAK, 0);
    tok_chk("R5 OUT nak", P_OUT, 5, 1, NAK, 0);
    tok_chk("R5 SETUP ignored", P_SETUP, 5, 1, NONE, 0);
    sw_wr(1, 8'h07);
    rd_chk("R3 sw clear", 1, 8'h07);
    sw_wr(1, 8'h87);
    rd_chk("R3 sw cannot set", 1, 8'h07);
    tok_chk("R7 IN DATA1", P_IN, 5, 1, DATA, 1);
  endtask

  task automatic t_prio;
    @(negedge clk);
    hs_ack_i = 1'b1; ev_ep_i = 4'd1;
    sw_we_i = 1'b1; sw_addr_i = 5'd1; sw_wdata_i = 8'h06;
    @(negedge clk);
    hs_ack_i = 1'b0; sw_we_i = 1'b0;
    rd_chk("R4 set wins, written tog kept", 1, 8'h86);
  endtask

  task automatic t_ctrl;
    sw_wr(2, 8'h0E);              // control, valid, tog 0
    tok_chk("R8 SETUP ack", P_SETUP, 5, 2, ACK, 0);
    rd_chk("R8 tog forced 1", 2, 8'h0F);
    tok_chk("R8 IN DATA1 after setup", P_IN, 5, 2, DATA, 1);
  endtask

  task automatic t_iso;
    sw_wr(3, 8'h16);              // iso, valid, tog 0
    ev(0, 1, 3);
    rd_chk("R9 end inverts iso tog", 3, 8'h97);
    tok_chk("R6 iso ignores flag, DATA0", P_IN, 5, 3, DATA, 0);
    tok_chk("R6 iso SETUP none", P_SETUP, 5, 3, NONE, 0);
    ev(1, 0, 3);
    rd_chk("R9 ack ignored on iso", 3, 8'h97);
    ev(0, 1, 1);
    rd_chk("R9 end ignored on bulk", 1, 8'h86);
  endtask

  task automatic t_stat;
    sw_wr(4, 8'h00);
    tok_chk("R10 disabled none", P_IN, 5, 4, NONE, 0);
    sw_wr(4, 8'h02);
    tok_chk("R10 stall", P_IN, 5, 4, STALL, 0);
    sw_wr(4, 8'h04);
    tok_chk("R10 nak", P_OUT, 5, 4, NAK, 0);
    sw_wr(3, 8'h14);
    tok_chk("R10 iso nak none", P_IN, 5, 3, NONE, 0);
  endtask

  task automatic t_usbrst;
    @(negedge clk);
    usb_rst_i = 1'b1;
    @(negedge clk);
    usb_rst_i = 1'b0;
    rd_chk("R2 addr cleared", 16, 8'h00);
    rd_chk("R2 flag kept, cfg cleared", 1, 8'h80);
    rd_chk("R2 ep2 cleared", 2, 8'h00);
    tok_chk("R2 R1 token after usb reset", P_IN, 5, 1, NONE, 0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #150000;
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_match();
    t_flow();
    t_prio();
    t_ctrl();
    t_iso();
    t_stat();
    t_usbrst();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule